// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital heart of a 12-bit successive-approximation analog-to-digital converter. It watches three control lines from a host (an active-low enable, a convert strobe and an upper-byte select) and decides whether a convert request is legitimate. A request counts only when the strobe falls while the block is idle, enable is low and upper-byte select is low, and the strobe then stays low for a minimum number of clocks. Once a request is accepted, the block drops its `idle` flag. It then walks a trial code from the most significant bit down to the least, one decision for every `TICKS_PER_BIT` cycles of the `tick` clock-enable. At each decision it keeps or clears the trial bit according to a one-bit comparator result.

When the last bit is decided, the finished code is written into the result register. The `idle` flag rises one cycle later, so a reader that acts on the rising edge of `idle` always sees the new value. For the whole time `idle` is low, every transition on the three control inputs is disregarded. A conversion therefore cannot be cut short or restarted. The sample/hold, DAC, comparator and reference sit outside this block.

Top module: `sar_ctl`

## Requirements
- R1: After reset, `idle` is 1, `result` is 0x000 and `trial_code` is 0x000.
- R2: With the default parameters, `idle` falls exactly 7 clock cycles (MIN_LOW_CLKS + 3) after `conv_strobe` falls, provided that `enable_n` and `upper_sel` are both low.
- R3: A falling strobe does not start a conversion while `enable_n` is high or `upper_sel` is high. A rising strobe never starts one.
- R4: A strobe low pulse shorter than MIN_LOW_CLKS cycles is rejected. A pulse of exactly MIN_LOW_CLKS cycles is accepted.
- R5: `idle` is low only during a conversion. With `tick` held at 1, it stays low for RES_BITS*TICKS_PER_BIT+1 cycles (25 with the defaults).
- R6: With an ideal comparator (`cmp_ge` = input code >= `trial_code`), `result` equals the input code. The coding is offset binary: 0x000 is the most negative level, 0x800 is zero and 0xFFF is the most positive level.
- R7: Bit decisions advance only on cycles where `tick` is 1. With `tick` held at 0, a conversion never finishes and the trial code does not move.
- R8: While `idle` is low, transitions on `conv_strobe`, `enable_n` and `upper_sel` are ignored. A strobe fall that happens during a conversion does not start another conversion afterwards.
- R9: `result` keeps its previous value throughout a conversion. It holds the new value in the last cycle before `idle` rises.
- R10: In the first cycle that `idle` is low, `trial_code` is 0x800, meaning the MSB is set and all lower bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_n | input | 1 | Active-low enable; asynchronous, synchronised inside |
| conv_strobe | input | 1 | Convert strobe; its falling edge requests a conversion |
| upper_sel | input | 1 | Upper-byte select; must be low for a start |
| tick | input | 1 | Clock-enable for bit-decision timing |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| trial_code | output | 12 | Code driven to the DAC |
| idle | output | 1 | High when idle, low during a conversion |
| result | output | 12 | Last completed conversion, offset binary |

## Verification
The bench targets the accept/reject boundary of the strobe pulse: a low pulse one cycle short must be dropped and an exact-width pulse must start a conversion. A qualifier that is off by one in either direction fails one of those two tests. It also tries falls with enable or upper-select high and a bare rising edge, any of which would start a conversion in a design with a loose start condition. It toggles all three controls in the middle of a conversion, which exposes a design that restarts, shortens or queues a late start. It freezes `tick` to catch decisions that run freely, and it probes the code endpoints 0x000, 0xFFF, 0x7FF and 0x800, where a wrong bit order or a lost final bit shows up first.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_CONV = 2'd1,
        ENG_XFER = 2'd2
    } eng_state_e;

    typedef enum logic {
        QL_WAIT = 1'b0,
        QL_ARM  = 1'b1
    } qual_state_e;

endpackage

// File: rtl/sar_ctl_sync.sv
module sar_ctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sar_ctl_qual.sv
module sar_ctl_qual
    import sar_ctl_pkg::*;
#(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    input  logic enable_n_s,
    input  logic upper_s,
    input  logic idle_i,
    output logic start_o
);

    localparam int CW = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;

    typedef struct packed {
        qual_state_e   state;
        logic [CW-1:0] cnt;
        logic          prev;
        logic          start;
    } qual_t;

    qual_t q_q, q_d;

    logic fall;
    logic blocked;

    always_comb begin
        q_d       = q_q;
        q_d.prev  = strobe_s;
        q_d.start = 1'b0;
        fall      = q_q.prev & ~strobe_s;
        blocked   = enable_n_s | upper_s;
        case (q_q.state)
            QL_WAIT: begin
                if (fall && !blocked && idle_i) begin
                    q_d.state = QL_ARM;
                    q_d.cnt   = CW'(1);
                end
            end
            QL_ARM: begin
                if (strobe_s || blocked) begin
                    q_d.state = QL_WAIT;
                end else if (q_q.cnt == CW'(MIN_LOW - 1)) begin
                    q_d.start = 1'b1;
                    q_d.state = QL_WAIT;
                end else begin
                    q_d.cnt = q_q.cnt + CW'(1);
                end
            end
            default: q_d.state = QL_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{state: QL_WAIT, cnt: '0, prev: 1'b0, start: 1'b0};
        else        q_q <= q_d;
    end

    assign start_o = q_q.start;

    initial begin
        assert_min_low_param_R4: assert (MIN_LOW >= 2)
            else $error("MIN_LOW must be at least 2");
    end

    assert_start_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.start |-> $past(!enable_n_s && !upper_s));

    assert_start_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.start |-> $past(!strobe_s));

    assert_arm_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == QL_ARM) |-> idle_i);

endmodule

// File: rtl/sar_ctl_engine.sv
module sar_ctl_engine
    import sar_ctl_pkg::*;
#(
    parameter int NBITS = 12,
    parameter int TPB   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             cmp_ge_i,
    output logic [NBITS-1:0] code_o,
    output logic [NBITS-1:0] result_o,
    output logic             idle_o
);

    localparam int IW = $clog2(NBITS);
    localparam int TW = (TPB > 1) ? $clog2(TPB) : 1;
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    typedef struct packed {
        eng_state_e       state;
        logic [NBITS-1:0] code;
        logic [NBITS-1:0] result;
        logic [IW-1:0]    idx;
        logic [TW-1:0]    tcnt;
    } eng_t;

    eng_t e_q, e_d;
    logic [NBITS-1:0] decided;

    always_comb begin
        e_d              = e_q;
        decided          = e_q.code;
        decided[e_q.idx] = cmp_ge_i;
        case (e_q.state)
            ENG_IDLE: begin
                if (start_i) begin
                    e_d.state = ENG_CONV;
                    e_d.code  = MSB_ONLY;
                    e_d.idx   = IW'(NBITS - 1);
                    e_d.tcnt  = '0;
                end
            end
            ENG_CONV: begin
                if (tick_i) begin
                    if (e_q.tcnt == TW'(TPB - 1)) begin
                        e_d.tcnt = '0;
                        e_d.code = decided;
                        if (e_q.idx == '0) begin
                            e_d.state  = ENG_XFER;
                            e_d.result = decided;
                        end else begin
                            e_d.code[e_q.idx - IW'(1)] = 1'b1;
                            e_d.idx                    = e_q.idx - IW'(1);
                        end
                    end else begin
                        e_d.tcnt = e_q.tcnt + TW'(1);
                    end
                end
            end
            ENG_XFER: e_d.state = ENG_IDLE;
            default:  e_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{state: ENG_IDLE, code: '0, result: '0, idx: '0, tcnt: '0};
        else        e_q <= e_d;
    end

    assign code_o   = e_q.code;
    assign result_o = e_q.result;
    assign idle_o   = (e_q.state == ENG_IDLE);

    assert_result_held_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state != ENG_CONV) |=> $stable(e_q.result));

    assert_msb_trial_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ENG_IDLE && start_i) |=> (e_q.code == MSB_ONLY));

    assert_frozen_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ENG_CONV && !tick_i) |=> ($stable(e_q.code) && e_q.state == ENG_CONV));

    assert_release_after_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ENG_XFER) |=> idle_o);

endmodule

// File: rtl/sar_ctl.sv
module sar_ctl #(
    parameter int RES_BITS      = 12,
    parameter int TICKS_PER_BIT = 2,
    parameter int MIN_LOW_CLKS  = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_n,
    input  logic                conv_strobe,
    input  logic                upper_sel,
    input  logic                tick,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] trial_code,
    output logic                idle,
    output logic [RES_BITS-1:0] result
);

    logic [2:0] ctl_s;
    logic       start;
    logic       idle_w;

    sar_ctl_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({upper_sel, enable_n, conv_strobe}),
        .dout  (ctl_s)
    );

    sar_ctl_qual #(
        .MIN_LOW (MIN_LOW_CLKS)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_s   (ctl_s[0]),
        .enable_n_s (ctl_s[1]),
        .upper_s    (ctl_s[2]),
        .idle_i     (idle_w),
        .start_o    (start)
    );

    sar_ctl_engine #(
        .NBITS (RES_BITS),
        .TPB   (TICKS_PER_BIT)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .tick_i   (tick),
        .cmp_ge_i (cmp_ge),
        .code_o   (trial_code),
        .result_o (result),
        .idle_o   (idle_w)
    );

    assign idle = idle_w;

    assert_no_start_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> idle_w);

endmodule

// File: tb/sar_ctl_bench.sv
`timescale 1ns/1ps
module sar_ctl_bench;

    localparam int N   = 12;
    localparam int TPB = 2;
    localparam int ML  = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable_n = 1'b0;
    logic         conv_strobe = 1'b1;
    logic         upper_sel = 1'b0;
    logic         tick = 1'b1;
    logic [N-1:0] stim = '0;
    logic         cmp_ge;
    logic [N-1:0] trial_code;
    logic         idle;
    logic [N-1:0] result;

    int vecs = 0;
    int errs = 0;
    logic [N-1:0] held = '0;

    always #2.5 clk = ~clk;

    assign cmp_ge = (stim >= trial_code);

    sar_ctl #(
        .RES_BITS      (N),
        .TICKS_PER_BIT (TPB),
        .MIN_LOW_CLKS  (ML),
        .SYNC_STAGES   (2)
    ) u_sar_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_n    (enable_n),
        .conv_strobe (conv_strobe),
        .upper_sel   (upper_sel),
        .tick        (tick),
        .cmp_ge      (cmp_ge),
        .trial_code  (trial_code),
        .idle        (idle),
        .result      (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_for(input int cycles, input string req);
        bit stayed = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!idle) stayed = 1'b0;
        end
        check(stayed, req, stayed, 1);
        check(result == held, req, result, held);
    endtask

    // counts negedges from strobe fall (already driven) until idle drops
    task automatic wait_start(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (idle && n < 50);
    endtask

    // called in the first idle-low cycle; follows conversion to its end
    task automatic follow(input logic [N-1:0] v, input bit exact_len, input string req);
        int len = 1;
        logic [N-1:0] last_low = result;
        forever begin
            @(negedge clk);
            if (idle || len > 200) break;
            len++;
            last_low = result;
            if (len == 10) check(result == held, "R9 old result kept", result, held);
        end
        if (exact_len) check(len == N*TPB+1, "R5 conversion length", len, N*TPB+1);
        check(last_low == v, "R9 result before idle rise", last_low, v);
        check(result == v, req, result, v);
        held = v;
    endtask

    task automatic t_reset();
        check(idle == 1'b1, "R1 idle after reset", idle, 1);
        check(result == '0, "R1 result after reset", result, 0);
        check(trial_code == '0, "R1 trial after reset", trial_code, 0);
    endtask

    task automatic t_convert(input logic [N-1:0] v);
        int n;
        stim = v;
        @(negedge clk);
        conv_strobe = 1'b0;
        wait_start(n);
        check(n == ML+3, "R2 start latency", n, ML+3);
        check(trial_code == 12'h800, "R10 first trial", trial_code, 12'h800);
        follow(v, 1'b1, "R6 offset binary result");
        conv_strobe = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_inhibit_enable();
        @(negedge clk);
        enable_n = 1'b1;
        repeat (4) @(negedge clk);
        conv_strobe = 1'b0;
        idle_for(20, "R3 enable high blocks start");
        conv_strobe = 1'b1;
        repeat (4) @(negedge clk);
        enable_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_inhibit_upper();
        @(negedge clk);
        upper_sel = 1'b1;
        repeat (4) @(negedge clk);
        conv_strobe = 1'b0;
        idle_for(20, "R3 upper select blocks start");
        conv_strobe = 1'b1;
        repeat (4) @(negedge clk);
        upper_sel = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_rising_only();
        @(negedge clk);
        enable_n = 1'b1;
        conv_strobe = 1'b0;
        repeat (6) @(negedge clk);
        enable_n = 1'b0;
        repeat (6) @(negedge clk);
        conv_strobe = 1'b1;
        idle_for(20, "R3 rising strobe no start");
    endtask

    task automatic t_short_pulse();
        @(negedge clk);
        conv_strobe = 1'b0;
        repeat (ML-1) @(negedge clk);
        conv_strobe = 1'b1;
        idle_for(20, "R4 short pulse rejected");
    endtask

    task automatic t_exact_pulse(input logic [N-1:0] v);
        int n = 0;
        stim = v;
        @(negedge clk);
        conv_strobe = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (n == ML) conv_strobe = 1'b1;
        end while (idle && n < 50);
        check(n == ML+3, "R4 exact pulse accepted", n, ML+3);
        follow(v, 1'b1, "R4 exact pulse result");
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ignore_busy(input logic [N-1:0] v);
        int n;
        int len = 1;
        stim = v;
        @(negedge clk);
        conv_strobe = 1'b0;
        wait_start(n);
        forever begin
            @(negedge clk);
            if (idle || len > 200) break;
            len++;
            case (len)
                3:  conv_strobe = 1'b1;
                4:  enable_n = 1'b1;
                6:  enable_n = 1'b0;
                7:  upper_sel = 1'b1;
                9:  upper_sel = 1'b0;
                10: conv_strobe = 1'b0;
                default: ;
            endcase
        end
        check(len == N*TPB+1, "R8 length unchanged by inputs", len, N*TPB+1);
        check(result == v, "R8 result unaffected", result, v);
        held = v;
        idle_for(30, "R8 no late start from busy fall");
        conv_strobe = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_tick_freeze(input logic [N-1:0] v);
        int n;
        stim = v;
        @(negedge clk);
        conv_strobe = 1'b0;
        tick = 1'b0;
        wait_start(n);
        repeat (40) @(negedge clk);
        check(idle == 1'b0, "R7 no progress without tick", idle, 0);
        check(trial_code == 12'h800, "R7 trial frozen", trial_code, 12'h800);
        tick = 1'b1;
        follow(v, 1'b0, "R7 result after tick resumes");
        conv_strobe = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_convert(12'hA5C);
        t_convert(12'h000);
        t_convert(12'hFFF);
        t_convert(12'h800);
        t_convert(12'h7FF);
        t_convert(12'h001);
        t_inhibit_enable();
        t_inhibit_upper();
        t_rising_only();
        t_short_pulse();
        t_exact_pulse(12'h3C6);
        t_ignore_busy(12'h555);
        t_tick_freeze(12'hB19);
        t_convert(12'h2AA);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule